// File: doc/BRIEF.md
# Thresholded Exponential-Weighted Accumulator

This block takes a stream of signed fixed-point pairs (x, y) and builds, over one vector, the sum of y times exp(x). The sum covers only the pairs whose x lies strictly above a programmable negative cut-off, and a bias is added at the end. The exponential is never computed at run time. A small unsigned table, filled in at elaboration, holds exp(x) over a fixed span of non-positive x. The top entry is full scale and the bottom entry is zero. Each table weight multiplies the signed y, and the product is shifted right by the table width before it is added to the running sum, which removes the table scaling.

One pair is taken on every clock cycle. The pipeline has three registered stages: lookup with gating, multiply with truncation, and accumulate. A small state machine in the accumulate stage tells whether the incoming term opens a new vector or continues the current one. It has two states. `ACC_FRESH` means the next term starts a fresh sum, and `ACC_MIDVEC` means a vector is in progress. The transition from `ACC_FRESH` to `ACC_MIDVEC` is taken on a term that is not flagged last. The transition from `ACC_MIDVEC` to `ACC_FRESH` is taken on a term flagged last. Every other case holds the state, including a last-flagged term taken in `ACC_FRESH` (a one-sample vector). Threshold and bias are plain configuration inputs, held stable while a vector is in flight.

Top module: `exw_accum`

## Requirements
- R1: While reset is held and on the first cycle after it, `res_done` is 0 and `res_value` is 0; once reset is released, `in_ready` is 1.
- R2: x and threshold are two's complement with 8 fraction bits. A positive x is treated as 0. The table index is min(63, (-x) >> 6). An accepted pair adds floor(w·y / 256) to the sum, where w is the table entry at that index (arithmetic right shift, so negative y rounds toward minus infinity).
- R3: With a step of s = 0.25 and N = 64 entries, table entry k equals floor(255·(e^(-k·s) − e^(-63·s)) / (1 − e^(-63·s)) + 0.5). Entry 0 is 255 and entry 63 is 0.
- R4: A pair whose x is at or below the threshold (signed compare, equality included) adds nothing, whatever its y is.
- R5: The reported result is the vector's sum plus `cfg_bias`. A vector made only of gated pairs reports exactly the bias.
- R6: One pair is accepted per cycle with no stalls. `res_done` is high for exactly the one cycle that comes three cycles after the cycle in which the last-flagged pair was presented.
- R7: The sum restarts from zero with the first pair after a last-flagged pair, so vectors sent back to back give independent results.
- R8: A vector of a single pair (first and last at once) reports that pair's term plus bias.
- R9: `res_value` changes only on a cycle where `res_done` is high, and holds otherwise.
- R10: The sum does not overflow for a vector of 65536 pairs of extreme value (full-scale weight, y = 32767).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Pair present on the input |
| in_ready | output | 1 | Block can take a pair (high out of reset) |
| in_x | input | 16 | Signed x, 8 fraction bits, expected at most 0 |
| in_y | input | 16 | Signed y |
| in_last | input | 1 | Marks the final pair of a vector |
| cfg_thr | input | 16 | Signed cut-off, same format as x |
| cfg_bias | input | 33 | Signed bias added to each vector's sum |
| res_value | output | 34 | Signed result, sum plus bias |
| res_done | output | 1 | One-cycle pulse when res_value is updated |

## Verification
Single-pair vectors with y = 256 are swept over every table index, with two x values per bucket. This reads each weight straight out through the result and separates table errors from index errors. Mixed vectors contain pairs exactly at the cut-off, one code above it and far below it. These separate a strict comparison from an inclusive one, and a vector of gated pairs only isolates the bias path. Back-to-back vectors, a long pseudo-random stream with negative y, and a 65536-pair full-scale vector tell apart a missing clear, wrong truncation direction and accumulator overflow. The cycle of each done pulse is compared against the cycle in which its last pair was presented.

// File: rtl/exw_pkg.sv
package exw_pkg;

    // Accumulate-stage vector tracking
    typedef enum logic [0:0] {
        ACC_FRESH  = 1'b0,
        ACC_MIDVEC = 1'b1
    } acc_state_e;

    // Weight for table slot k: exp(-k*step) rescaled so slot 0 is full
    // scale and the final slot is zero. Step is 2^shift / 2^frac.
    function automatic int exw_tbl_entry(input int k, input int depth,
                                         input int shift, input int frac,
                                         input int ew);
        real step;
        real floor_val;
        real v;
        step      = real'(1 << shift) / real'(1 << frac);
        floor_val = $exp(-real'(depth - 1) * step);
        v = ($exp(-real'(k) * step) - floor_val) / (1.0 - floor_val)
            * real'((1 << ew) - 1);
        return $rtoi(v + 0.5);
    endfunction

endpackage

// File: rtl/exw_lut.sv
module exw_lut #(
    parameter int XW        = 16,
    parameter int YW        = 16,
    parameter int EW        = 8,
    parameter int DEPTH     = 64,
    parameter int IDX_SHIFT = 6,
    parameter int FRAC      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take,
    input  logic signed [XW-1:0] x,
    input  logic signed [YW-1:0] y,
    input  logic                 last,
    input  logic signed [XW-1:0] thr,
    output logic                 s1_valid,
    output logic        [EW-1:0] s1_w,
    output logic signed [YW-1:0] s1_y,
    output logic                 s1_last
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [EW-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        localparam int VAL = exw_pkg::exw_tbl_entry(g, DEPTH, IDX_SHIFT, FRAC, EW);
        assign rom[g] = VAL[EW-1:0];
    end

    logic [XW:0]   mag;
    logic [XW:0]   bucket;
    logic [IW-1:0] idx;
    logic          gated;
    logic [EW-1:0] w_next;

    always_comb begin
        if (x > 0) mag = '0;
        else       mag = -{x[XW-1], x};
        bucket = mag >> IDX_SHIFT;
        if (bucket > (XW+1)'(DEPTH - 1)) idx = IW'(DEPTH - 1);
        else                             idx = bucket[IW-1:0];
        gated  = (x <= thr);
        w_next = gated ? '0 : rom[idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_w     <= '0;
            s1_y     <= '0;
            s1_last  <= 1'b0;
        end else begin
            s1_valid <= take;
            s1_w     <= w_next;
            s1_y     <= y;
            s1_last  <= take & last;
        end
    end
endmodule

// File: rtl/exw_mul.sv
module exw_mul #(
    parameter int YW = 16,
    parameter int EW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s1_valid,
    input  logic        [EW-1:0] s1_w,
    input  logic signed [YW-1:0] s1_y,
    input  logic                 s1_last,
    output logic                 s2_valid,
    output logic signed [YW:0]   s2_term,
    output logic                 s2_last
);
    localparam int PW = EW + 1 + YW;
    localparam int TW = YW + 1;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;

    always_comb begin
        prod   = $signed({{(PW-EW){1'b0}}, s1_w}) *
                 $signed({{(PW-YW){s1_y[YW-1]}}, s1_y});
        scaled = prod >>> EW;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_term  <= '0;
            s2_last  <= 1'b0;
        end else begin
            s2_valid <= s1_valid;
            s2_term  <= scaled[TW-1:0];
            s2_last  <= s1_valid & s1_last;
        end
    end
endmodule

// File: rtl/exw_acc.sv
module exw_acc #(
    parameter int TW   = 17,
    parameter int ACCW = 33
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  s2_valid,
    input  logic signed [TW-1:0]  s2_term,
    input  logic                  s2_last,
    input  logic signed [ACCW-1:0] bias,
    output logic signed [ACCW:0]  res_value,
    output logic                  res_done
);
    import exw_pkg::*;

    acc_state_e state, state_n;
    logic signed [ACCW-1:0] acc;
    logic signed [ACCW-1:0] base;
    logic signed [ACCW-1:0] sum;
    logic                   close;

    // next state and datapath
    always_comb begin
        state_n = state;
        close   = s2_valid & s2_last;
        unique case (state)
            ACC_FRESH: begin
                base = '0;
                if (s2_valid && !s2_last) state_n = ACC_MIDVEC;
            end
            ACC_MIDVEC: begin
                base = acc;
                if (close) state_n = ACC_FRESH;
            end
        endcase
        sum = base + {{(ACCW-TW){s2_term[TW-1]}}, s2_term};
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ACC_FRESH;
        else        state <= state_n;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            res_value <= '0;
            res_done  <= 1'b0;
        end else begin
            res_done <= close;
            if (s2_valid) acc <= sum;
            if (close)
                res_value <= {sum[ACCW-1], sum} + {bias[ACCW-1], bias};
        end
    end
endmodule

// File: rtl/exw_accum.sv
module exw_accum #(
    parameter int XW        = 16,
    parameter int YW        = 16,
    parameter int EW        = 8,
    parameter int DEPTH     = 64,
    parameter int IDX_SHIFT = 6,
    parameter int FRAC      = 8,
    parameter int CNTW      = 16,
    localparam int TW       = YW + 1,
    localparam int ACCW     = TW + CNTW,
    localparam int RW       = ACCW + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic signed [XW-1:0]  in_x,
    input  logic signed [YW-1:0]  in_y,
    input  logic                  in_last,
    input  logic signed [XW-1:0]  cfg_thr,
    input  logic signed [ACCW-1:0] cfg_bias,
    output logic signed [RW-1:0]  res_value,
    output logic                  res_done
);
    logic                 take;
    logic                 s1_valid;
    logic        [EW-1:0] s1_w;
    logic signed [YW-1:0] s1_y;
    logic                 s1_last;
    logic                 s2_valid;
    logic signed [TW-1:0] s2_term;
    logic                 s2_last;

    assign in_ready = rst_n;
    assign take     = in_valid & in_ready;

    exw_lut #(
        .XW(XW), .YW(YW), .EW(EW), .DEPTH(DEPTH),
        .IDX_SHIFT(IDX_SHIFT), .FRAC(FRAC)
    ) u_lut (
        .clk(clk), .rst_n(rst_n), .take(take),
        .x(in_x), .y(in_y), .last(in_last), .thr(cfg_thr),
        .s1_valid(s1_valid), .s1_w(s1_w), .s1_y(s1_y), .s1_last(s1_last)
    );

    exw_mul #(.YW(YW), .EW(EW)) u_mul (
        .clk(clk), .rst_n(rst_n),
        .s1_valid(s1_valid), .s1_w(s1_w), .s1_y(s1_y), .s1_last(s1_last),
        .s2_valid(s2_valid), .s2_term(s2_term), .s2_last(s2_last)
    );

    exw_acc #(.TW(TW), .ACCW(ACCW)) u_acc (
        .clk(clk), .rst_n(rst_n),
        .s2_valid(s2_valid), .s2_term(s2_term), .s2_last(s2_last),
        .bias(cfg_bias), .res_value(res_value), .res_done(res_done)
    );
endmodule

// File: rtl/exw_accum_chk.sv
module exw_accum_chk #(
    parameter int XW = 16,
    parameter int EW = 8,
    parameter int RW = 34
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 in_last,
    input logic signed [XW-1:0] in_x,
    input logic signed [XW-1:0] cfg_thr,
    input logic                 s1_valid,
    input logic        [EW-1:0] s1_w,
    input logic signed [RW-1:0] res_value,
    input logic                 res_done
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!res_done && res_value == '0));

    // R4
    gate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_x <= cfg_thr) |=> (s1_valid && s1_w == '0));

    // R6
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |-> ##3 res_done);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_done |-> $stable(res_value));
endmodule

bind exw_accum exw_accum_chk #(.XW(XW), .EW(EW), .RW(RW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .in_x(in_x), .cfg_thr(cfg_thr),
    .s1_valid(s1_valid), .s1_w(s1_w),
    .res_value(res_value), .res_done(res_done)
);

// File: tb/test_exw_accum.sv
module test_exw_accum;
    localparam int NT = 64;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic signed [15:0] in_x = '0;
    logic signed [15:0] in_y = '0;
    logic               in_last = 1'b0;
    logic signed [15:0] cfg_thr = -16'sd2560;
    logic signed [32:0] cfg_bias = '0;
    logic signed [33:0] res_value;
    logic               res_done;

    exw_accum i_exw_accum (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_x(in_x), .in_y(in_y), .in_last(in_last), .cfg_thr(cfg_thr),
        .cfg_bias(cfg_bias), .res_value(res_value), .res_done(res_done)
    );

    always #2.5 clk = ~clk;

    int     total = 0;
    int     bad   = 0;
    longint cyc   = 0;
    longint wt [NT];
    longint exp_acc = 0;
    longint exp_val [$];
    longint exp_cyc [$];
    string  exp_req [$];
    longint got_val [$];
    longint got_cyc [$];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk)
        if (rst_n && res_done) begin
            got_val.push_back(longint'(res_value));
            got_cyc.push_back(cyc);
        end

    task automatic check(input string req, input longint act, input longint expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic longint term_of(input int x, input int y, input int thr);
        int d;
        int k;
        if (x <= thr) return 0;
        d = (x > 0) ? 0 : -x;
        k = d / 64;
        if (k > NT - 1) k = NT - 1;
        return (wt[k] * longint'(y)) >>> 8;
    endfunction

    // called at a negedge; returns at the next negedge
    task automatic send(input int x, input int y, input bit last, input string req);
        in_valid = 1'b1;
        in_x = 16'(x);
        in_y = 16'(y);
        in_last = last;
        exp_acc += term_of(x, y, int'(cfg_thr));
        if (last) begin
            exp_val.push_back(exp_acc + longint'(cfg_bias));
            exp_cyc.push_back(cyc + 3);
            exp_req.push_back(req);
            exp_acc = 0;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        int n;
        n = (got_val.size() < exp_val.size()) ? got_val.size() : exp_val.size();
        check("R6 done count", got_val.size(), exp_val.size());
        for (int i = 0; i < n; i++) begin
            check(exp_req[i], got_val[i], exp_val[i]);
            check("R6 done cycle", got_cyc[i], exp_cyc[i]);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int unsigned lcg;
        int x;
        int y;
        real lo;
        lo = $exp(-63.0 * 0.25);
        for (int k = 0; k < NT; k++)
            wt[k] = longint'($floor(255.0 * ($exp(-0.25 * k) - lo) / (1.0 - lo) + 0.5));
        // R3 endpoints of the reference table itself
        check("R3 entry0", wt[0], 255);
        check("R3 entry63", wt[NT-1], 0);

        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 done in reset", res_done, 0);
        check("R1 value in reset", res_value, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", res_done, 0);
        check("R1 value after reset", res_value, 0);
        check("R1 ready", in_ready, 1);

        // R8 / R2 single pairs, both signs, positive x treated as zero
        cfg_thr = -16'sd2560;
        cfg_bias = '0;
        send(0, 100, 1'b1, "R8 single positive");
        send(0, -100, 1'b1, "R2 negative y floors");
        send(300, 1000, 1'b1, "R2 positive x as zero");
        send(-1, -7, 1'b1, "R2 small negative truncation");
        idle(4);

        // R3 sweep of every table slot, two x values per slot
        cfg_thr = -16'sh8000;
        for (int k = 0; k < NT; k++) begin
            send(-k * 64, 256, 1'b1, "R3 table slot");
            send(-k * 64 - 37, 256, 1'b1, "R3 table slot inner");
        end
        send(-20000, 256, 1'b1, "R2 index clamp");
        idle(4);

        // R4 cut-off gating, equality included
        cfg_thr = -16'sd2560;
        cfg_bias = 33'sd12345;
        send(-2560, 30000, 1'b0, "R4");
        send(-2559, 30000, 1'b0, "R4");
        send(-3000, -5000, 1'b0, "R4");
        send(0, 1, 1'b1, "R4 mixed gating");
        send(-2560, 32767, 1'b0, "R5");
        send(-9000, -32768, 1'b1, "R5 gated only gives bias");
        idle(4);

        // R5 negative bias, R7 back-to-back vectors
        cfg_bias = -33'sd77777;
        send(-100, 2000, 1'b0, "R7");
        send(-700, -3000, 1'b1, "R5 negative bias");
        send(-50, 111, 1'b0, "R7");
        send(-1200, 222, 1'b1, "R7 clear between vectors");
        send(-64, -32768, 1'b1, "R7 third vector");
        idle(4);

        // R2 / R7 pseudo-random vectors with varied threshold
        lcg = 32'h1234_5678;
        for (int v = 0; v < 6; v++) begin
            cfg_thr  = 16'(-1024 - v * 600);
            cfg_bias = 33'(v * 1000 - 2500);
            for (int i = 0; i < 300; i++) begin
                lcg = lcg * 32'd1664525 + 32'd1013904223;
                x = -int'(lcg[27:16] % 4600);
                y = int'($signed(lcg[15:0]));
                send(x, y, i == 299, "R2 random stream");
            end
            idle(4);
        end

        // R10 long full-scale vector
        cfg_thr = -16'sd2560;
        cfg_bias = '0;
        for (int i = 0; i < 65536; i++)
            send(0, 32767, i == 65535, "R10 no overflow");
        idle(6);
        finish_run();
    end
endmodule